// File: doc/BRIEF.md
# Folded Residue Code Generator

This block is a digital model of a three-channel folding front end with moduli 3, 4 and 5. For an integer sample index it produces, per channel, the symmetrical residue of a triangular fold, a slope flag telling whether that point lies on the rising or the falling side of the fold, and the thermometer word that the channel's comparator bank would show. It gives a reverse converter a known-good stimulus, and it serves as a reference model in self-checking environments.

Each channel follows a triangle that counts up from 0 to its modulus m and back down to 1. Every value is held for three consecutive indices, one per channel, so the period is 6m. Channel k is advanced by k index steps. These phase offsets mean that between neighbouring indices exactly one comparator anywhere in the system changes state. The index is reduced modulo 360, the least common multiple of the three periods, and is captured on a valid strobe. The outputs are registered and appear on the next clock.

Top module: `fold_code_gen`

## Requirements
- R1: While reset is asserted and after its release until the first accepted index, out_valid is 0 and every residue, slope bit and thermometer bit is 0.
- R2: out_valid is 1 exactly in the cycle after a cycle with in_valid high, and 0 otherwise.
- R3: An index of 360 or more is treated as index minus 360, giving the same outputs as that reduced index.
- R4: For channel k (k = 0, 1, 2, modulus m = 3 + k), let p = (h + k) mod 6m and d = p / 3 (integer division). The residue is d when d <= m and 2m - d otherwise. It appears on out_res bits [3k+2:3k].
- R5: The slope bit of channel k (out_fold bit k) is 0 when d <= m, which includes the peak d = m and the zero point, and 1 when d > m. A set slope bit always comes with a residue strictly between 0 and m.
- R6: Channel k's thermometer has m bits. Exactly residue-many of its lowest bits are 1 and the rest are 0. The field sits at out_therm[2:0] for channel 0, [6:3] for channel 1 and [11:7] for channel 2.
- R7: For indices h and h+1 mod 360, including 359 to 0, the 12-bit thermometer words differ in exactly one bit.
- R8: In a cycle with in_valid low, residues, slope bits and thermometers keep their previous values whatever in_index carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Index strobe |
| in_index | input | 9 | Sample index, reduced modulo 360 |
| out_valid | output | 1 | Outputs updated this cycle |
| out_res | output | 9 | Three 3-bit residues, channel 0 in the low bits |
| out_fold | output | 3 | Slope bit per channel, 1 = falling |
| out_therm | output | 12 | Concatenated comparator thermometers |

## Verification
A full ascending sweep of 0 to 359 followed by 0 shows the per-channel triangles with their three-fold holds and channel offsets. The same sweep checks the single-bit change between neighbours across the wrap, which would catch a wrong shift or a wrong hold length. Directed points sit at each channel's peak, at the first falling step and at the zero point, which separates a slope bit that marks the peak as rising from one that marks it as falling. Indices from 360 to 511, random indices with random gaps in the strobe, and index changes while the strobe is low separate correct reduction and holding from stale or leaking updates.

// File: rtl/fold_pkg.sv
package fold_pkg;
  localparam int NUM_CH  = 3;
  localparam int MOD_LO  = 3;
  localparam int MOD_HI  = MOD_LO + NUM_CH - 1;
  localparam int IDX_W   = 9;
  localparam int RES_W   = $clog2(MOD_HI + 1);
  localparam int RANGE   = 2 * NUM_CH * MOD_LO * (MOD_LO + 1) * (MOD_LO + 2);
  localparam int THERM_W = NUM_CH * MOD_LO + (NUM_CH * (NUM_CH - 1)) / 2;

  function automatic int modulus(input int k);
    return MOD_LO + k;
  endfunction

  function automatic int therm_lsb(input int k);
    int acc;
    acc = 0;
    for (int j = 0; j < k; j++) acc += modulus(j);
    return acc;
  endfunction
endpackage

// File: rtl/fold_index_wrap.sv
module fold_index_wrap #(
  parameter int IDX_W = 9,
  parameter int RANGE = 360
) (
  input  logic [IDX_W-1:0] idx_raw,
  output logic [IDX_W-1:0] idx_mod
);
  localparam logic [IDX_W-1:0] RANGE_V = IDX_W'(RANGE);

  always_comb begin
    if (idx_raw >= RANGE_V) idx_mod = idx_raw - RANGE_V;
    else                    idx_mod = idx_raw;
  end

  // R3
  always_comb begin
    range_chk : assert (idx_mod < RANGE_V);
  end
endmodule

// File: rtl/fold_channel.sv
module fold_channel #(
  parameter int IDX_W = 9,
  parameter int MOD   = 3,
  parameter int SHIFT = 0,
  parameter int NREP  = 3,
  parameter int RES_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output logic [RES_W-1:0] res_q,
  output logic             fold_q,
  output logic [MOD-1:0]   therm_q
);
  localparam int PERIOD = 2 * MOD * NREP;

  logic [RES_W-1:0] res_d;
  logic             fold_d;
  logic [MOD-1:0]   therm_d;
  int unsigned      pos;
  int unsigned      step;

  always_comb begin
    pos  = (32'(idx) + SHIFT) % PERIOD;
    step = pos / NREP;
    if (step <= MOD) begin
      res_d  = RES_W'(step);
      fold_d = 1'b0;
    end else begin
      res_d  = RES_W'(2 * MOD - step);
      fold_d = 1'b1;
    end
    for (int j = 0; j < MOD; j++) therm_d[j] = (j < 32'(res_d));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      fold_q  <= 1'b0;
      therm_q <= '0;
    end else if (en) begin
      res_q   <= res_d;
      fold_q  <= fold_d;
      therm_q <= therm_d;
    end
  end

  // R5
  fall_range_chk : assert property (@(posedge clk) disable iff (!rst_n)
    fold_q |-> (res_q != '0 && 32'(res_q) < MOD));

  // R4
  res_bound_chk : assert property (@(posedge clk) disable iff (!rst_n)
    32'(res_q) <= MOD);

  // R6
  therm_shape_chk : assert property (@(posedge clk) disable iff (!rst_n)
    ((therm_q & (therm_q + 1'b1)) == '0) && ($countones(therm_q) == 32'(res_q)));

  // R8
  hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(res_q) && $stable(fold_q) && $stable(therm_q)));
endmodule

// File: rtl/fold_code_gen.sv
module fold_code_gen
  import fold_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [IDX_W-1:0]          in_index,
  output logic                      out_valid,
  output logic [NUM_CH*RES_W-1:0]   out_res,
  output logic [NUM_CH-1:0]         out_fold,
  output logic [THERM_W-1:0]        out_therm
);
  logic [IDX_W-1:0] idx_mod;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;
  logic             valid_d;

  fold_index_wrap #(.IDX_W(IDX_W), .RANGE(RANGE)) u_wrap (
    .idx_raw (in_index),
    .idx_mod (idx_mod)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam int M   = modulus(k);
    localparam int LSB = therm_lsb(k);
    fold_channel #(
      .IDX_W (IDX_W),
      .MOD   (M),
      .SHIFT (k),
      .NREP  (NUM_CH),
      .RES_W (RES_W)
    ) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (in_valid),
      .idx     (idx_mod),
      .res_q   (out_res[k*RES_W +: RES_W]),
      .fold_q  (out_fold[k]),
      .therm_q (out_therm[LSB +: M])
    );
  end

  always_comb begin
    valid_d = in_valid;
    idx_d   = in_valid ? idx_mod : idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      idx_q     <= '0;
    end else begin
      out_valid <= valid_d;
      idx_q     <= idx_d;
    end
  end

  // R2
  valid_lat_chk : assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  valid_idle_chk : assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R7
  gray_step_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid) &&
     (($past(idx_q) == IDX_W'(RANGE - 1)) ? (idx_q == '0) : (idx_q == $past(idx_q) + 1'b1)))
    |-> ($countones(out_therm ^ $past(out_therm)) == 1));
endmodule

// File: tb/fold_code_gen_bench.sv
module fold_code_gen_bench;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [8:0]  in_index;
  logic        out_valid;
  logic [8:0]  out_res;
  logic [2:0]  out_fold;
  logic [11:0] out_therm;

  int checks;
  int failures;

  fold_code_gen u_fold_code_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_index  (in_index),
    .out_valid (out_valid),
    .out_res   (out_res),
    .out_fold  (out_fold),
    .out_therm (out_therm)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [23:0] expect_all(input int h);
    logic [8:0]  r;
    logic [2:0]  f;
    logic [11:0] t;
    int lsb, m, p, d, v;
    r = '0; f = '0; t = '0; lsb = 0;
    for (int k = 0; k < 3; k++) begin
      m = 3 + k;
      p = ((h % 360) + k) % (6 * m);
      d = p / 3;
      v = (d <= m) ? d : 2 * m - d;
      r[3*k +: 3] = 3'(v);
      f[k] = (d > m);
      for (int j = 0; j < m; j++) t[lsb + j] = (j < v);
      lsb += m;
    end
    return {r, f, t};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input int idx, input string req);
    logic [23:0] e;
    @(negedge clk);
    in_valid = 1'b1;
    in_index = 9'(idx);
    @(negedge clk);
    e = expect_all(idx);
    check(req, {8'd0, out_res, out_fold, out_therm}, {8'd0, e});
    check("R2", {31'd0, out_valid}, 32'd1);
  endtask

  initial begin : watchdog
    #500000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    logic [11:0] prev_t;
    logic [23:0] held;
    checks = 0; failures = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_index = '0;
    void'($urandom(32'd4242));
    #12;
    check("R1", {8'd0, out_valid, out_res, out_fold, out_therm}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1", {8'd0, out_valid, out_res, out_fold, out_therm}, 32'd0);

    // R4 R5 known point and peaks/first falling steps
    apply(25, "R4");
    apply(9, "R5");    // ch0 peak d=3
    apply(12, "R5");   // ch0 first falling
    apply(11, "R5");   // ch1 peak
    apply(13, "R5");   // ch2 peak
    apply(16, "R5");   // ch2 first falling
    apply(0, "R6");

    // R3 reduction
    for (int i = 360; i < 512; i += 7) apply(i, "R3");
    apply(511, "R3");
    apply(360, "R3");

    // R7 full sweep with wrap
    apply(0, "R7");
    prev_t = out_therm;
    for (int i = 1; i <= 360; i++) begin
      apply(i % 360, "R4");
      check("R7", 32'($countones(out_therm ^ prev_t)), 32'd1);
      prev_t = out_therm;
    end

    // R8 hold while strobe low, R2 valid drop
    apply(100, "R8");
    held = {out_res, out_fold, out_therm};
    @(negedge clk); in_valid = 1'b0; in_index = 9'd200;
    @(negedge clk);
    check("R2", {31'd0, out_valid}, 32'd0);
    check("R8", {8'd0, out_res, out_fold, out_therm}, {8'd0, held});
    in_index = 9'd7;
    @(negedge clk);
    check("R8", {8'd0, out_res, out_fold, out_therm}, {8'd0, held});

    // random with gaps
    for (int n = 0; n < 300; n++) begin
      apply(int'($urandom_range(511, 0)), "R4");
      if ($urandom_range(3, 0) == 0) begin
        held = {out_res, out_fold, out_therm};
        @(negedge clk); in_valid = 1'b0; in_index = 9'($urandom_range(511, 0));
        @(negedge clk);
        check("R8", {8'd0, out_res, out_fold, out_therm}, {8'd0, held});
        check("R2", {31'd0, out_valid}, 32'd0);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule